// File: doc/BRIEF.md
# Infrared Narrow-Pulse Transmit Encoder

This block sits between a UART transmitter and an infrared emitter driver. It watches the serial bit leaving the transmitter and turns it into a return-to-zero pulse train. Each logic-zero bit becomes one short active-high pulse at the start of the bit. Each logic-one bit leaves the line dark for the whole bit.

Bit timing comes from outside the block. One tick marks each bit boundary, and a finer tick splits every bit period into 32 equal sub-ticks. The 32 sub-ticks give the resolution needed for the narrowest pulse, which is 1/32 of a bit. A two-bit select picks the pulse width at run time from four fractions of the bit period. The select and the serial bit are both captured only at a bit boundary, so a change in the middle of a bit cannot cut or stretch a pulse that is already running. An enable input forces the line low and drops any pulse in progress.

Top module: `ir_pulse_encoder`

## Requirements
- R1: When `widthSel` is 2'b00 at a bit boundary and the bit is zero, the pulse lasts 6 sub-ticks, which is 3/16 of the bit period.
- R2: When `widthSel` is 2'b01 at a bit boundary and the bit is zero, the pulse lasts 2 sub-ticks, which is 1/16 of the bit period.
- R3: When `widthSel` is 2'b10 at a bit boundary and the bit is zero, the pulse lasts 1 sub-tick, which is 1/32 of the bit period.
- R4: When `widthSel` is 2'b11 at a bit boundary and the bit is zero, the pulse lasts 8 sub-ticks, which is 1/4 of the bit period. No pulse is ever longer than this.
- R5: A pulse starts at the bit boundary. `irOut` goes high in the cycle after the clock edge where `bitTick` is sampled high. It falls after the edge where the Nth following `subTick` is sampled, where N is the width in sub-ticks. The `subTick` that comes with `bitTick` is not counted.
- R6: A bit of value 1 on `txBit` at the boundary produces no pulse. `irOut` stays low for the whole bit.
- R7: While `encEn` is low, `irOut` is low in the same cycle. A pulse cut short by disabling does not resume when the block is enabled again.
- R8: `widthSel` and `txBit` are sampled only on `bitTick`. Changing them during a bit has no effect on the pulse of that bit.
- R9: During and right after reset `irOut` is low, and the held pulse state clears to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| encEn | input | 1 | Encoder enable; low forces the line idle |
| bitTick | input | 1 | One-cycle strobe at each bit boundary; must coincide with a subTick |
| subTick | input | 1 | One-cycle strobe, 32 per bit period |
| txBit | input | 1 | Serial bit from the UART transmitter |
| widthSel | input | 2 | Pulse width select: 00=3/16, 01=1/16, 10=1/32, 11=1/4 |
| irOut | output | 1 | Encoded infrared line, active high |

## Verification
The assertions assume that `bitTick` only ever arrives together with a `subTick`. They also assume that exactly 32 sub-ticks separate two bit boundaries, so a pulse always ends before the next boundary. The bench builds both ticks from one cycle counter with a fixed number of clocks per sub-tick, and it raises `bitTick` only on sub-tick zero. The bench changes `encEn` only at a boundary, or once on purpose in the middle of a pulse. It changes `widthSel` and `txBit` only at a boundary or at a fixed point in the middle of the bit.

// File: rtl/ir_enc_pkg.sv
package ir_enc_pkg;
  localparam int SUB_PER_BIT = 32;
  localparam int CNT_W = $clog2(SUB_PER_BIT / 4 + 1);

  typedef struct packed {
    logic load;
    logic step;
    logic clear;
  } ctrlStrobes_t;

  function automatic logic [CNT_W-1:0] widthToSubs(input logic [1:0] sel);
    case (sel)
      2'b00:   return CNT_W'(SUB_PER_BIT * 3 / 16);
      2'b01:   return CNT_W'(SUB_PER_BIT / 16);
      2'b10:   return CNT_W'(SUB_PER_BIT / 32);
      default: return CNT_W'(SUB_PER_BIT / 4);
    endcase
  endfunction
endpackage

// File: rtl/ir_enc_ctrl.sv
module ir_enc_ctrl
  import ir_enc_pkg::*;
(
  input  logic         encEn,
  input  logic         bitTick,
  input  logic         subTick,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes.clear = ~encEn;
    strobes.load  = encEn & bitTick;
    strobes.step  = encEn & subTick & ~bitTick;
  end
endmodule

// File: rtl/ir_enc_datapath.sv
module ir_enc_datapath
  import ir_enc_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ctrlStrobes_t strobes,
  input  logic         txBit,
  input  logic [1:0]   widthSel,
  output logic         pulseActive
);
  logic [CW-1:0] remainSubs;
  logic [CW-1:0] loadVal;

  always_comb begin
    loadVal = txBit ? '0 : CW'(widthToSubs(widthSel));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remainSubs <= '0;
    end else if (strobes.clear) begin
      remainSubs <= '0;
    end else if (strobes.load) begin
      remainSubs <= loadVal;
    end else if (strobes.step && remainSubs != '0) begin
      remainSubs <= remainSubs - 1'b1;
    end
  end

  assign pulseActive = (remainSubs != '0);
endmodule

// File: rtl/ir_pulse_encoder.sv
module ir_pulse_encoder
  import ir_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       encEn,
  input  logic       bitTick,
  input  logic       subTick,
  input  logic       txBit,
  input  logic [1:0] widthSel,
  output logic       irOut
);
  ctrlStrobes_t strobes;
  logic pulseActive;

  ir_enc_ctrl ctrl_i (
    .encEn   (encEn),
    .bitTick (bitTick),
    .subTick (subTick),
    .strobes (strobes)
  );

  ir_enc_datapath #(.CW(CNT_W)) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .txBit       (txBit),
    .widthSel    (widthSel),
    .pulseActive (pulseActive)
  );

  assign irOut = encEn & pulseActive;
endmodule

// File: rtl/ir_pulse_encoder_chk.sv
module ir_pulse_encoder_chk
  import ir_enc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       encEn,
  input logic       bitTick,
  input logic       subTick,
  input logic       txBit,
  input logic       irOut
);
  localparam int MAX_SUBS = SUB_PER_BIT / 4;
  logic [7:0] highSubs;

  always_ff @(posedge clk) begin
    if (!rst_n || !irOut) highSubs <= '0;
    else if (subTick && !bitTick) highSubs <= highSubs + 1'b1;
  end

  // R4: a pulse never spans more than a quarter bit of sub-ticks
  a_r4_max_width: assert property (@(posedge clk) disable iff (!rst_n)
    int'(highSubs) <= MAX_SUBS);

  // R5: a pulse can only begin right after a zero-bit boundary
  a_r5_rise_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irOut) |-> $past(bitTick && encEn && !txBit));

  // R6: a one bit leaves the line dark
  a_r6_no_pulse_for_one: assert property (@(posedge clk) disable iff (!rst_n)
    (bitTick && encEn && txBit) |=> !irOut);

  // R7: disabled encoder keeps the line low
  a_r7_low_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !encEn |-> !irOut);

  // R8: the line only changes state on sub-tick edges while enabled
  a_r8_hold_between_subticks: assert property (@(posedge clk) disable iff (!rst_n)
    (irOut && encEn && !subTick && !bitTick) |=> (irOut || !encEn));
endmodule

bind ir_pulse_encoder ir_pulse_encoder_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .encEn   (encEn),
  .bitTick (bitTick),
  .subTick (subTick),
  .txBit   (txBit),
  .irOut   (irOut)
);

// File: tb/ir_pulse_encoder_tb.sv
module ir_pulse_encoder_tb_top;
  localparam int P = 3;
  localparam int SUBS = 32;
  localparam int BITCYC = SUBS * P;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic encEn = 1'b0;
  logic bitTick = 1'b0;
  logic subTick = 1'b0;
  logic txBit = 1'b1;
  logic [1:0] widthSel = 2'b00;
  logic irOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ir_pulse_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .encEn(encEn), .bitTick(bitTick),
    .subTick(subTick), .txBit(txBit), .widthSel(widthSel), .irOut(irOut)
  );

  function automatic int subsFor(input logic [1:0] s);
    case (s)
      2'b00: return 6;
      2'b01: return 2;
      2'b10: return 1;
      default: return 8;
    endcase
  endfunction

  function automatic int expHigh(input logic b, input logic [1:0] s, input logic e, input int dropAt);
    int w;
    if (!e || b) return 0;
    w = subsFor(s) * P;
    if (dropAt > 0 && dropAt < w) return dropAt;
    return w;
  endfunction

  function automatic string tagFor(input logic b, input logic [1:0] s, input logic e);
    if (!e) return "R7";
    if (b) return "R6";
    case (s)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one bit period; s2/b2 are applied mid-bit, dropAt>0 disables at that cycle
  task automatic runBit(input logic b, input logic [1:0] s, input logic e,
                        input logic [1:0] s2, input logic b2, input int dropAt,
                        input string tag);
    int highCnt = 0;
    int firstHigh = -1;
    int exp;
    for (int c = 0; c < BITCYC; c++) begin
      @(negedge clk);
      if (c > 0 && irOut === 1'b1) begin
        highCnt++;
        if (firstHigh < 0) firstHigh = c;
      end
      bitTick = (c == 0);
      subTick = (c % P == 0);
      if (c == 0) begin txBit = b; widthSel = s; encEn = e; end
      if (c == 4 * P + 1) begin widthSel = s2; txBit = b2; end
      if (dropAt > 0 && c == dropAt) encEn = 1'b0;
    end
    @(negedge clk);
    if (irOut === 1'b1) highCnt++;
    bitTick = 1'b0;
    subTick = 1'b0;
    exp = expHigh(b, s, e, dropAt);
    check(highCnt == exp, tag, highCnt, exp);
    if (exp > 0) check(firstHigh == 1, "R5 start", firstHigh, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (4) @(negedge clk);
    check(irOut === 1'b0, "R9 reset", int'(irOut), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(irOut === 1'b0, "R9 after reset", int'(irOut), 0);

    runBit(1'b0, 2'b00, 1'b1, 2'b00, 1'b0, 0, "R1");
    runBit(1'b0, 2'b01, 1'b1, 2'b01, 1'b0, 0, "R2");
    runBit(1'b0, 2'b10, 1'b1, 2'b10, 1'b0, 0, "R3");
    runBit(1'b0, 2'b11, 1'b1, 2'b11, 1'b0, 0, "R4");
    runBit(1'b1, 2'b11, 1'b1, 2'b11, 1'b1, 0, "R6");
    // R8: mid-bit width and bit changes ignored
    runBit(1'b0, 2'b10, 1'b1, 2'b11, 1'b1, 0, "R8 width/bit change");
    runBit(1'b1, 2'b11, 1'b1, 2'b00, 1'b0, 0, "R8 one then zero");
    // R7: disabled bit and mid-pulse drop
    runBit(1'b0, 2'b11, 1'b0, 2'b11, 1'b0, 0, "R7 disabled");
    runBit(1'b0, 2'b11, 1'b1, 2'b11, 1'b0, 5, "R7 drop");
    check(irOut === 1'b0, "R7 stays low", int'(irOut), 0);
    runBit(1'b0, 2'b00, 1'b1, 2'b00, 1'b0, 0, "R7 re-enable R1");

    for (int i = 0; i < 40; i++) begin
      logic b, e, b2;
      logic [1:0] s, s2;
      b  = 1'($urandom % 2);
      e  = ($urandom % 8) != 0;
      s  = 2'($urandom % 4);
      s2 = 2'($urandom % 4);
      b2 = 1'($urandom % 2);
      runBit(b, s, e, s2, b2, 0, tagFor(b, s, e));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule